// File: doc/BRIEF.md
# Self-Synchronising Serial Register Port with Sticky Converter Status

This block is the register-access front end of a measurement converter. A host drives chip select, a serial clock and a serial data line. The block oversamples these with its own system clock. While chip select is active, it discards 0 bits until the first 1 arrives. That 1 opens an eight-bit command, which names a register and a direction. The block then moves that register's data MSB first: it drives read data on the falling serial-clock edge and samples write data on the rising edge.

The block also keeps the converter's status flags. Each completed conversion latches its result into a read-only result register. The same conversion can raise a sign flag, an over-range flag or an under-range flag, judged against two writable signed thresholds. A low-battery level input raises its own flag. A status read clears only those flags that were set when the read began, and a flag whose condition still holds stays set. The data-ready flag is cleared only by reading the result register.

Top module: `sercmd_front`

## Requirements
- R1: While chip select is low, 0 bits sampled before a command are ignored. The first 1 bit is taken as the start bit, bit 7 of the command byte.
- R2: The command byte is sent MSB first. Bit 7 is the start bit, bit 6 is the direction (1 = read, 0 = write), bits 5..1 are the register address and bit 0 is ignored. The address map is: 0x00 status (8 bits, read-only), 0x01 control (16 bits), 0x02 result (16 bits, read-only), 0x03 over-range threshold (16 bits), 0x04 under-range threshold (16 bits). Any other address reads as 0 over 16 bits and ignores writes.
- R3: Data follows the command MSB first, with a width fixed by the address. Read bits change after falling serial-clock edges, starting with the falling edge after the command's eighth rising edge. Write bits are sampled on rising edges.
- R4: A write to the status or result register leaves its contents unchanged.
- R5: The status byte resets to 0x00. Bit 7 is sign, bit 6 is over-range, bit 5 is under-range, bit 4 is low-battery and bit 3 is data-ready. Bits 2..0 read as 0.
- R6: A completed conversion latches its result and sets data-ready. It sets sign if the result is negative, over-range if the result is greater than the over-range threshold, and under-range if the result is less than the under-range threshold, with all comparisons signed. Low-battery is set in every cycle that its input is high.
- R7: At the end of a complete status read, the sign, over-range, under-range and low-battery flags are cleared. A flag whose condition still holds at that moment stays set; the condition is the latest result for the first three and the input level for low-battery.
- R8: Data-ready is cleared only by a complete read of the result register. A status read leaves it set.
- R9: A status read returns the flags as they stand when the command byte completes. A flag raised during the read is neither reported by that read nor cleared by it.
- R10: Raising chip select aborts any partial transfer and updates no register. The next frame is decoded normally.
- R11: At reset the control register is 0x0000, the over-range threshold is 0x7FFF and the under-range threshold is 0x8000. The control register's value is always visible on `ctrl_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host, 0 when not reading |
| conv_done | input | 1 | One-cycle strobe: a conversion completed |
| conv_result | input | 16 | Signed result valid with conv_done |
| low_batt | input | 1 | Low-battery condition level |
| ctrl_word | output | 16 | Current control register value |

## Verification
The checker watches several rules on every cycle. A conversion always sets data-ready, and data-ready can fall only when a result read completes. Low-battery follows its input, and the sign flag survives any cycle without a status read. The control and result registers change only through a completed write or a conversion, and a write never commits outside an active frame. The directed scenarios are the only way to show the serial framing. They cover leading zeros, the ignored bit 0, aborts and read-only writes. They also show the clear-on-read rule with the condition still present and with it gone, the snapshot timing when an event lands mid-read, and the bit-exact read-back values.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int STAT_W = 8;
    localparam int CMD_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // register addresses
    localparam addr_t A_STAT = 5'h00;
    localparam addr_t A_CTRL = 5'h01;
    localparam addr_t A_RES  = 5'h02;
    localparam addr_t A_OVR  = 5'h03;
    localparam addr_t A_UND  = 5'h04;

    localparam word_t CTRL_RST = 16'h0000;
    localparam word_t OVR_RST  = 16'h7FFF;
    localparam word_t UND_RST  = 16'h8000;

    typedef enum logic [1:0] {
        PH_HUNT,
        PH_CMD,
        PH_RD,
        PH_WR
    } phase_e;

    function automatic logic is_byte_reg(addr_t a);
        return a == A_STAT;
    endfunction

    function automatic logic is_writable(addr_t a);
        return (a == A_CTRL) || (a == A_OVR) || (a == A_UND);
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic sdi_s
);

    typedef struct packed {
        logic [SYNC_N:0]   ck;
        logic [SYNC_N-1:0] cs;
        logic [SYNC_N-1:0] di;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.ck = {q.ck[SYNC_N-1:0], sclk};
        d.cs = {q.cs[SYNC_N-2:0], cs_n};
        d.di = {q.di[SYNC_N-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ck <= '0;
            q.cs <= '1;
            q.di <= '0;
        end else begin
            q <= d;
        end
    end

    // data taken from the same stage as the newer clock sample
    assign sclk_rise = q.ck[SYNC_N-1] & ~q.ck[SYNC_N];
    assign sclk_fall = ~q.ck[SYNC_N-1] & q.ck[SYNC_N];
    assign sel       = ~q.cs[SYNC_N-1];
    assign sdi_s     = q.di[SYNC_N-1];

endmodule

// File: rtl/sercmd_status.sv
module sercmd_status
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  word_t             conv_result,
    input  word_t             ovr_thr,
    input  word_t             und_thr,
    input  logic              low_batt,
    input  logic              snap_take,
    input  logic              stat_rd_done,
    input  logic              res_rd_done,
    output logic [STAT_W-1:0] stat,
    output word_t             result
);

    // flag order in the snapshot: sign, over, under, low-battery
    typedef struct packed {
        word_t      res;
        logic       sgn;
        logic       ovr;
        logic       und;
        logic       lowb;
        logic       rdy;
        logic [3:0] snap;
    } st_t;

    st_t   q, d;
    word_t res_eff;
    logic  c_sgn, c_ovr, c_und;
    logic [3:0] clr;

    always_comb begin
        d       = q;
        res_eff = conv_done ? conv_result : q.res;
        c_sgn   = res_eff[DATA_W-1];
        c_ovr   = $signed(res_eff) > $signed(ovr_thr);
        c_und   = $signed(res_eff) < $signed(und_thr);
        clr     = stat_rd_done ? q.snap : 4'b0000;

        d.res  = res_eff;
        d.sgn  = (conv_done & c_sgn) | (q.sgn & ~(clr[3] & ~c_sgn));
        d.ovr  = (conv_done & c_ovr) | (q.ovr & ~(clr[2] & ~c_ovr));
        d.und  = (conv_done & c_und) | (q.und & ~(clr[1] & ~c_und));
        d.lowb = low_batt | (q.lowb & ~clr[0]);
        d.rdy  = conv_done | (q.rdy & ~res_rd_done);
        if (snap_take) begin
            d.snap = {q.sgn, q.ovr, q.und, q.lowb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat   = {q.sgn, q.ovr, q.und, q.lowb, q.rdy, 3'b000};
    assign result = q.res;

endmodule

// File: rtl/sercmd_regs.sv
module sercmd_regs
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  addr_t             wr_addr,
    input  word_t             wr_data,
    input  addr_t             rd_addr,
    input  logic [STAT_W-1:0] stat,
    input  word_t             result,
    output word_t             rd_data,
    output word_t             ctrl,
    output word_t             ovr_thr,
    output word_t             und_thr
);

    typedef struct packed {
        word_t ctrl;
        word_t ovr;
        word_t und;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  d.ctrl = wr_data;
                A_OVR:   d.ovr  = wr_data;
                A_UND:   d.und  = wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_STAT:  rd_data = {{(DATA_W-STAT_W){1'b0}}, stat};
            A_CTRL:  rd_data = q.ctrl;
            A_RES:   rd_data = result;
            A_OVR:   rd_data = q.ovr;
            A_UND:   rd_data = q.und;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl <= CTRL_RST;
            q.ovr  <= OVR_RST;
            q.und  <= UND_RST;
        end else begin
            q <= d;
        end
    end

    assign ctrl    = q.ctrl;
    assign ovr_thr = q.ovr;
    assign und_thr = q.und;

endmodule

// File: rtl/sercmd_front.sv
module sercmd_front
    import sercmd_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              low_batt,
    output logic [DATA_W-1:0] ctrl_word
);

    localparam logic [CNT_W-1:0] N_WORD = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] N_BYTE = CNT_W'(STAT_W);
    localparam logic [CNT_W-1:0] N_CMD  = CNT_W'(CMD_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-2:0] sh;
        word_t             tx;
        logic              sdo;
        addr_t             addr;
        logic              byte_w;
    } fr_t;

    fr_t q, d;

    logic              rise, fall, sel, sdi_s;
    logic              wr_en, snap_take, stat_rd_done, res_rd_done;
    addr_t             wr_addr, rd_addr, cmd_addr;
    word_t             wr_data, rd_data, wr_word, ovr_thr, und_thr, result_w;
    logic [STAT_W-1:0] stat_w;
    logic              cmd_rd, last;
    logic [CNT_W-1:0]  cnt_inc, nbits;

    sercmd_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .sel       (sel),
        .sdi_s     (sdi_s)
    );

    always_comb begin
        d            = q;
        wr_en        = 1'b0;
        snap_take    = 1'b0;
        stat_rd_done = 1'b0;
        res_rd_done  = 1'b0;

        // start bit sits at sh[6] when the eighth bit arrives
        cmd_rd   = q.sh[5];
        cmd_addr = q.sh[ADDR_W-1:0];
        rd_addr  = cmd_addr;
        wr_word  = {q.sh, sdi_s};
        cnt_inc  = q.cnt + CNT_W'(1);
        nbits    = q.byte_w ? N_BYTE : N_WORD;
        last     = (cnt_inc == nbits);
        wr_addr  = q.addr;
        wr_data  = q.byte_w ? {{(DATA_W-STAT_W){1'b0}}, wr_word[STAT_W-1:0]} : wr_word;

        if (!sel) begin
            d.phase = PH_HUNT;
            d.cnt   = '0;
            d.sdo   = 1'b0;
        end else begin
            case (q.phase)
                PH_HUNT: begin
                    if (rise && sdi_s) begin
                        d.phase = PH_CMD;
                        d.cnt   = CNT_W'(1);
                        d.sh    = {{(DATA_W-2){1'b0}}, 1'b1};
                    end
                end
                PH_CMD: begin
                    if (rise) begin
                        d.sh  = wr_word[DATA_W-2:0];
                        d.cnt = cnt_inc;
                        if (q.cnt == N_CMD) begin
                            d.addr   = cmd_addr;
                            d.byte_w = is_byte_reg(cmd_addr);
                            d.cnt    = '0;
                            if (cmd_rd) begin
                                d.phase   = PH_RD;
                                snap_take = (cmd_addr == A_STAT);
                                d.tx      = is_byte_reg(cmd_addr)
                                          ? {rd_data[STAT_W-1:0], {(DATA_W-STAT_W){1'b0}}}
                                          : rd_data;
                            end else begin
                                d.phase = PH_WR;
                            end
                        end
                    end
                end
                PH_RD: begin
                    if (fall) begin
                        d.sdo = q.tx[DATA_W-1];
                        d.tx  = {q.tx[DATA_W-2:0], 1'b0};
                    end
                    if (rise) begin
                        d.cnt = cnt_inc;
                        if (last) begin
                            d.phase      = PH_HUNT;
                            d.cnt        = '0;
                            d.sdo        = 1'b0;
                            stat_rd_done = (q.addr == A_STAT);
                            res_rd_done  = (q.addr == A_RES);
                        end
                    end
                end
                PH_WR: begin
                    if (rise) begin
                        d.sh  = wr_word[DATA_W-2:0];
                        d.cnt = cnt_inc;
                        if (last) begin
                            d.phase = PH_HUNT;
                            d.cnt   = '0;
                            wr_en   = is_writable(q.addr);
                        end
                    end
                end
                default: d.phase = PH_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase  <= PH_HUNT;
            q.cnt    <= '0;
            q.sh     <= '0;
            q.tx     <= '0;
            q.sdo    <= 1'b0;
            q.addr   <= '0;
            q.byte_w <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sercmd_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done    (conv_done),
        .conv_result  (conv_result),
        .ovr_thr      (ovr_thr),
        .und_thr      (und_thr),
        .low_batt     (low_batt),
        .snap_take    (snap_take),
        .stat_rd_done (stat_rd_done),
        .res_rd_done  (res_rd_done),
        .stat         (stat_w),
        .result       (result_w)
    );

    sercmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .stat    (stat_w),
        .result  (result_w),
        .rd_data (rd_data),
        .ctrl    (ctrl_word),
        .ovr_thr (ovr_thr),
        .und_thr (und_thr)
    );

    assign sdo = q.sdo;

endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk
    import sercmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic              low_batt,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [STAT_W-1:0] stat,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              sel,
    input logic              stat_rd_done,
    input logic              res_rd_done
);

    p_drdy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> stat[3]);

    p_drdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[3] && !res_rd_done) |=> stat[3]);

    p_lowb_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        low_batt |=> stat[4]);

    p_sign_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[7] && !stat_rd_done) |=> stat[7]);

    p_ctrl_only_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> $past(wr_en && (wr_addr == A_CTRL)));

    p_commit_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sel);

    p_result_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(conv_done));

endmodule

bind sercmd_front sercmd_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done    (conv_done),
    .low_batt     (low_batt),
    .ctrl_word    (ctrl_word),
    .stat         (stat_w),
    .result       (result_w),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .sel          (sel),
    .stat_rd_done (stat_rd_done),
    .res_rd_done  (res_rd_done)
);

// File: tb/sercmd_front_test.sv
module sercmd_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        conv_done = 1'b0;
    logic        low_batt = 1'b0;
    logic [15:0] conv_result = 16'h0000;
    logic        sdo;
    logic [15:0] ctrl_word;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sercmd_front uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .sdi         (sdi),
        .sdo         (sdo),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .low_batt    (low_batt),
        .ctrl_word   (ctrl_word)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic s);
        sdi = b;
        half();
        s = sdo;
        sclk = 1'b1;
        half();
        sclk = 1'b0;
    endtask

    // full frame; pulse_at >= 0 pulses low_batt before that data bit
    task automatic xfer(input int lead, input logic rw, input logic [4:0] a, input logic x,
                        input logic [15:0] wd, input int pulse_at, output logic [15:0] rd);
        logic       s;
        logic [7:0] c;
        int         nb;
        c  = {1'b1, rw, a, x};
        nb = (a == 5'h00) ? 8 : 16;
        rd = '0;
        @(negedge clk);
        cs_n = 1'b0;
        half();
        for (int i = 0; i < lead; i++) spi_bit(1'b0, s);
        for (int i = 7; i >= 0; i--) spi_bit(c[i], s);
        for (int i = nb - 1; i >= 0; i--) begin
            if (i == pulse_at) begin
                low_batt = 1'b1;
                repeat (2) @(negedge clk);
                low_batt = 1'b0;
            end
            spi_bit(wd[i], s);
            rd = {rd[14:0], s};
        end
        half();
        cs_n = 1'b1;
        sdi  = 1'b0;
        half();
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] v);
        logic [15:0] dummy;
        xfer(0, 1'b0, a, 1'b0, v, -1, dummy);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
        xfer(0, 1'b1, a, 1'b0, 16'h0000, -1, v);
    endtask

    task automatic convert(input logic [15:0] v);
        @(negedge clk);
        conv_result = v;
        conv_done   = 1'b1;
        @(negedge clk);
        conv_done   = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R11 ctrl_word at reset", ctrl_word, 16'h0000);
        rd_reg(5'h00, v);  check("R5 status at reset", v, 16'h0000);
        rd_reg(5'h01, v);  check("R11 control reads 0000", v, 16'h0000);
        rd_reg(5'h03, v);  check("R11 over threshold reset", v, 16'h7FFF);
        rd_reg(5'h04, v);  check("R11 under threshold reset", v, 16'h8000);
    endtask

    task automatic t_leading_zeros();
        logic [15:0] v;
        logic [15:0] dummy;
        xfer(5, 1'b0, 5'h01, 1'b0, 16'hA5C3, -1, dummy);
        check("R1 write after leading zeros", ctrl_word, 16'hA5C3);
        xfer(3, 1'b1, 5'h01, 1'b0, 16'h0000, -1, v);
        check("R3 read back after leading zeros", v, 16'hA5C3);
    endtask

    task automatic t_dont_care_bit();
        logic [15:0] v;
        logic [15:0] dummy;
        xfer(0, 1'b0, 5'h01, 1'b1, 16'h1234, -1, dummy);
        check("R2 write with bit0 set", ctrl_word, 16'h1234);
        xfer(1, 1'b1, 5'h01, 1'b1, 16'h0000, -1, v);
        check("R2 read with bit0 set", v, 16'h1234);
    endtask

    task automatic t_read_only();
        logic [15:0] v;
        wr_reg(5'h02, 16'h5555);
        rd_reg(5'h02, v);  check("R4 result ignores write", v, 16'h0000);
        wr_reg(5'h00, 16'h00FF);
        rd_reg(5'h00, v);  check("R4 status ignores write", v, 16'h0000);
        wr_reg(5'h1F, 16'hBEEF);
        rd_reg(5'h1F, v);  check("R2 unmapped reads zero", v, 16'h0000);
        check("R4 control untouched", ctrl_word, 16'h1234);
    endtask

    task automatic t_abort();
        logic       s;
        logic [7:0] c;
        logic [15:0] v;
        c = {1'b1, 1'b0, 5'h01, 1'b0};
        @(negedge clk);
        cs_n = 1'b0;
        half();
        for (int i = 7; i >= 0; i--) spi_bit(c[i], s);
        for (int i = 0; i < 7; i++) spi_bit(1'b1, s);
        half();
        cs_n = 1'b1;
        sdi  = 1'b0;
        half();
        check("R10 partial write leaves control", ctrl_word, 16'h1234);
        rd_reg(5'h01, v);
        check("R10 frame after abort", v, 16'h1234);
    endtask

    task automatic t_ranges();
        logic [15:0] v;
        wr_reg(5'h03, 16'h0100);
        wr_reg(5'h04, 16'hFF00);
        convert(16'h0200);
        rd_reg(5'h00, v);  check("R6 over-range and data-ready", v, 16'h0048);
        rd_reg(5'h00, v);  check("R7 over-range kept while present", v, 16'h0048);
        convert(16'h0010);
        rd_reg(5'h00, v);  check("R7 over-range sticky after cause gone", v, 16'h0048);
        rd_reg(5'h00, v);  check("R8 status read keeps data-ready", v, 16'h0008);
        rd_reg(5'h02, v);  check("R6 result latched", v, 16'h0010);
        rd_reg(5'h00, v);  check("R8 result read clears data-ready", v, 16'h0000);
    endtask

    task automatic t_negative();
        logic [15:0] v;
        convert(16'hFE00);
        rd_reg(5'h00, v);  check("R6 sign and under-range", v, 16'h00A8);
        rd_reg(5'h02, v);  check("R8 result read value", v, 16'hFE00);
        rd_reg(5'h00, v);  check("R7 sign/under kept while present", v, 16'h00A0);
        convert(16'h0000);
        rd_reg(5'h00, v);  check("R7 flags sticky before read", v, 16'h00A8);
        rd_reg(5'h00, v);  check("R7 flags cleared after read", v, 16'h0008);
        rd_reg(5'h02, v);  check("R8 zero result", v, 16'h0000);
    endtask

    task automatic t_low_batt();
        logic [15:0] v;
        @(negedge clk);
        low_batt = 1'b1;
        repeat (4) @(negedge clk);
        low_batt = 1'b0;
        rd_reg(5'h00, v);  check("R6 low-battery pulse latched", v, 16'h0010);
        rd_reg(5'h00, v);  check("R7 low-battery cleared", v, 16'h0000);
        low_batt = 1'b1;
        rd_reg(5'h00, v);  check("R6 low-battery level", v, 16'h0010);
        rd_reg(5'h00, v);  check("R7 low-battery kept while high", v, 16'h0010);
        low_batt = 1'b0;
        rd_reg(5'h00, v);  check("R7 low-battery still latched", v, 16'h0010);
        rd_reg(5'h00, v);  check("R7 low-battery cleared at last", v, 16'h0000);
    endtask

    task automatic t_snapshot();
        logic [15:0] v;
        xfer(0, 1'b1, 5'h00, 1'b0, 16'h0000, 4, v);
        check("R9 snapshot excludes mid-read event", v, 16'h0000);
        rd_reg(5'h00, v);  check("R9 mid-read event not lost", v, 16'h0010);
        rd_reg(5'h00, v);  check("R9 cleared on following read", v, 16'h0000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_leading_zeros();
        t_dont_care_bit();
        t_read_only();
        t_abort();
        t_ranges();
        t_negative();
        t_low_batt();
        t_snapshot();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule